// File: doc/BRIEF.md
# Memory Transfer Unit with Completion Handshake

This block sits between a processor's internal data bus and an external memory bus whose response time is not fixed. It owns two registers: an address register that feeds the memory address lines, and a data register that can exchange words with either bus. The control sequencer moves a word by pulsing separate enables: load the address, start a read or a write, then wait until the addressed device reports that the transfer is finished. The processor is stalled for as long as that report is missing, so a device may take any number of cycles.

A read is issued by loading the address and requesting a read in one step. In the next step the data register is told to accept the memory bus and the sequencer waits. In the last step the data register drives the internal bus into the destination register. A write loads the address, then loads the data register from the internal bus and requests the write. It then drives the data register onto the memory bus and waits. The data register has four independent enables: load from inside, drive inside, load from memory, drive memory.

Top module: `mem_xfer_unit`

## Requirements
- R1: After reset, mem_rd, mem_wr, stall, ibus_out_en and mem_wdata_en are 0, and both registers hold 0, so mem_addr is 0.
- R2: When addr_ld is high at a clock edge and no transfer is outstanding, mem_addr shows ibus_in from the next cycle. addr_ld is ignored while a transfer is outstanding, including the completing edge.
- R3: rd_go at an edge with no transfer outstanding raises mem_rd from the next cycle. mem_rd stays high through the first cycle in which mem_done is high and is low in the cycle after it.
- R4: wr_go at an edge with no transfer outstanding raises mem_wr from the next cycle. mem_wr stays high through the first cycle with mem_done high and is low after it.
- R5: rd_go and wr_go are ignored while a transfer is outstanding, including the completing edge. If both are high with nothing outstanding, the read is started and the write is dropped, so mem_rd and mem_wr are never high together.
- R6: stall is high exactly when wait_done is high, a transfer is outstanding and mem_done is low. It clears in the same cycle mem_done rises, and it is 0 when wait_done is high with nothing outstanding.
- R7: The data register takes mem_rdata only at an edge where dreg_ld_ext, mem_rd and mem_done are all high. At any other edge mem_rdata has no effect.
- R8: dreg_ld_int loads ibus_in into the data register at an edge. It is ignored while a write is outstanding, so the word sent to memory cannot change during the wait.
- R9: ibus_out_en follows dreg_drv_int. ibus_out carries the data register while it is high and 0 otherwise (default build).
- R10: mem_wdata_en follows dreg_drv_ext. mem_wdata carries the data register while it is high and 0 otherwise (default build).
- R11: When a memory capture (R7) and dreg_ld_int fall on the same edge, the memory word wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ibus_in | input | DW | Value currently on the internal bus |
| addr_ld | input | 1 | Load address register from internal bus |
| rd_go | input | 1 | Start a memory read |
| wr_go | input | 1 | Start a memory write |
| wait_done | input | 1 | Sequencer is waiting for completion |
| dreg_ld_int | input | 1 | Load data register from internal bus |
| dreg_drv_int | input | 1 | Drive data register onto internal bus |
| dreg_ld_ext | input | 1 | Load data register from memory bus |
| dreg_drv_ext | input | 1 | Drive data register onto memory bus |
| ibus_out | output | DW | Data register value toward internal bus |
| ibus_out_en | output | 1 | Internal bus drive enable |
| stall | output | 1 | Hold the sequencer in its current step |
| mem_addr | output | DW | Memory address |
| mem_rd | output | 1 | Read request, held until completion |
| mem_wr | output | 1 | Write request, held until completion |
| mem_wdata | output | DW | Write data toward memory |
| mem_wdata_en | output | 1 | Memory data drive enable |
| mem_rdata | input | DW | Read data from memory |
| mem_done | input | 1 | Device reports transfer complete |

## Verification
The main stimulus is a stream of reads and writes to random addresses. The device model answers each one after a random 0 to 5 cycles, so both the zero-wait case and long waits occur. Counting stall cycles against the model's chosen latency tells a stall that clears on completion apart from one that clears a cycle late or early. Reads compared with a reference array tell a capture on the completing edge apart from a capture of the junk the model drives before it. Directed runs pulse address loads, new requests and inside loads during a pending wait, which shows whether the held address and data are protected. Further directed runs issue read and write together at idle, load from inside on the capture edge, and raise wait_done with nothing outstanding.

// File: rtl/mxu_pkg.sv
package mxu_pkg;
   typedef enum logic [1:0] {
      XFER_IDLE = 2'd0,
      XFER_RD   = 2'd1,
      XFER_WR   = 2'd2
   } xfer_e;
endpackage

// File: rtl/mxu_handshake.sv
module mxu_handshake
   import mxu_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic rd_go,
   input  logic wr_go,
   input  logic wait_done,
   input  logic mem_done,
   output logic mem_rd,
   output logic mem_wr,
   output logic busy,
   output logic rd_fin,
   output logic stall
);
   xfer_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         XFER_IDLE: begin
            if (rd_go)      state_d = XFER_RD;
            else if (wr_go) state_d = XFER_WR;
         end
         XFER_RD, XFER_WR: begin
            if (mem_done) state_d = XFER_IDLE;
         end
         default: state_d = XFER_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= XFER_IDLE;
      else        state_q <= state_d;
   end

   assign mem_rd = (state_q == XFER_RD);
   assign mem_wr = (state_q == XFER_WR);
   assign busy   = (state_q != XFER_IDLE);
   assign rd_fin = mem_rd && mem_done;
   assign stall  = wait_done && busy && !mem_done;

   AST_RD_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_rd && !mem_wr && rd_go) |=> mem_rd);                          // R3
   AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_rd) |-> $past(mem_done));                                 // R3
   AST_WR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_wr) |-> $past(mem_done));                                 // R4
   AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));                                               // R5
   AST_STALL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> ((mem_rd || mem_wr) && !mem_done));                       // R6
endmodule

// File: rtl/mxu_addr_reg.sv
module mxu_addr_reg #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic          busy,
   input  logic [DW-1:0] ibus_in,
   output logic [DW-1:0] addr_q
);
   initial begin
      assert (DW >= 1) else $error("mxu_addr_reg: DW must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           addr_q <= '0;
      else if (ld && !busy) addr_q <= ibus_in;
   end

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(addr_q));                                          // R2
endmodule

// File: rtl/mxu_data_reg.sv
module mxu_data_reg #(
   parameter int DW        = 32,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_int,
   input  logic          ld_ext,
   input  logic          drv_int,
   input  logic          drv_ext,
   input  logic          wr_busy,
   input  logic          rd_fin,
   input  logic [DW-1:0] ibus_in,
   input  logic [DW-1:0] mem_rdata,
   output logic [DW-1:0] ibus_out,
   output logic          ibus_out_en,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_wdata_en
);
   logic [DW-1:0] data_q;
   logic          take_ext;
   logic          take_int;

   initial begin
      assert (DW >= 1) else $error("mxu_data_reg: DW must be at least 1");
   end

   assign take_ext = ld_ext && rd_fin;
   assign take_int = ld_int && !wr_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        data_q <= '0;
      else if (take_ext) data_q <= mem_rdata;
      else if (take_int) data_q <= ibus_in;
   end

   assign ibus_out_en  = drv_int;
   assign mem_wdata_en = drv_ext;

   generate
      if (ZERO_IDLE) begin : g_gated
         assign ibus_out  = drv_int ? data_q : '0;
         assign mem_wdata = drv_ext ? data_q : '0;
      end else begin : g_raw
         assign ibus_out  = data_q;
         assign mem_wdata = data_q;
      end
   endgenerate

   AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_ext && rd_fin) |=> (data_q == $past(mem_rdata)));               // R11
   AST_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_fin && !ld_int) |=> $stable(data_q));                          // R7
   AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_busy && !rd_fin) |=> $stable(data_q));                          // R8
endmodule

// File: rtl/mem_xfer_unit.sv
module mem_xfer_unit #(
   parameter int DW        = 32,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] ibus_in,
   input  logic          addr_ld,
   input  logic          rd_go,
   input  logic          wr_go,
   input  logic          wait_done,
   input  logic          dreg_ld_int,
   input  logic          dreg_drv_int,
   input  logic          dreg_ld_ext,
   input  logic          dreg_drv_ext,
   output logic [DW-1:0] ibus_out,
   output logic          ibus_out_en,
   output logic          stall,
   output logic [DW-1:0] mem_addr,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_wdata_en,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_done
);
   logic busy;
   logic rd_fin;

   mxu_handshake u_hs (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_go     (rd_go),
      .wr_go     (wr_go),
      .wait_done (wait_done),
      .mem_done  (mem_done),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .busy      (busy),
      .rd_fin    (rd_fin),
      .stall     (stall)
   );

   mxu_addr_reg #(.DW(DW)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (addr_ld),
      .busy    (busy),
      .ibus_in (ibus_in),
      .addr_q  (mem_addr)
   );

   mxu_data_reg #(.DW(DW), .ZERO_IDLE(ZERO_IDLE)) u_data (
      .clk          (clk),
      .rst_n        (rst_n),
      .ld_int       (dreg_ld_int),
      .ld_ext       (dreg_ld_ext),
      .drv_int      (dreg_drv_int),
      .drv_ext      (dreg_drv_ext),
      .wr_busy      (mem_wr),
      .rd_fin       (rd_fin),
      .ibus_in      (ibus_in),
      .mem_rdata    (mem_rdata),
      .ibus_out     (ibus_out),
      .ibus_out_en  (ibus_out_en),
      .mem_wdata    (mem_wdata),
      .mem_wdata_en (mem_wdata_en)
   );

   AST_ADDR_STEADY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !mem_done) |=> $stable(mem_addr));                       // R2
endmodule

// File: tb/mem_xfer_unit_bench.sv
module mem_xfer_unit_bench;
   localparam int DW = 32;
   localparam int NA = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] ibus_in = '0;
   logic addr_ld = 0, rd_go = 0, wr_go = 0, wait_done = 0;
   logic dreg_ld_int = 0, dreg_drv_int = 0, dreg_ld_ext = 0, dreg_drv_ext = 0;
   logic [DW-1:0] ibus_out, mem_addr, mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          ibus_out_en, stall, mem_rd, mem_wr, mem_wdata_en;
   logic          mem_done = 1'b0;

   int errors = 0;
   int checks = 0;

   logic [DW-1:0] dev_mem [NA];
   logic [DW-1:0] exp_mem [NA];
   logic [DW-1:0] exp_dreg = '0;
   int  force_lat = -1;
   int  last_lat  = 0;
   int  dev_cnt   = 0;
   bit  dev_busy  = 0;

   always #5 clk = ~clk;

   mem_xfer_unit #(.DW(DW)) u_mem_xfer_unit (
      .clk(clk), .rst_n(rst_n), .ibus_in(ibus_in), .addr_ld(addr_ld),
      .rd_go(rd_go), .wr_go(wr_go), .wait_done(wait_done),
      .dreg_ld_int(dreg_ld_int), .dreg_drv_int(dreg_drv_int),
      .dreg_ld_ext(dreg_ld_ext), .dreg_drv_ext(dreg_drv_ext),
      .ibus_out(ibus_out), .ibus_out_en(ibus_out_en), .stall(stall),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_wdata_en(mem_wdata_en),
      .mem_rdata(mem_rdata), .mem_done(mem_done)
   );

   function automatic logic [DW-1:0] init_word(input int a);
      return (32'h9E37_79B9 * (a + 1)) ^ 32'h0F0F_1234;
   endfunction

   // device model: completion after 0..5 cycles, junk on read data otherwise
   always @(negedge clk) begin
      if (mem_rd || mem_wr) begin
         if (!dev_busy) begin
            dev_busy = 1;
            dev_cnt  = 0;
            last_lat = (force_lat >= 0) ? force_lat : int'($urandom % 6);
         end else begin
            dev_cnt++;
         end
         mem_done  <= (dev_cnt == last_lat);
         mem_rdata <= (mem_rd && dev_cnt == last_lat) ? dev_mem[mem_addr[3:0]] : $urandom;
      end else begin
         dev_busy = 0;
         mem_done  <= 1'b0;
         mem_rdata <= $urandom;
      end
   end

   always @(posedge clk) begin
      if (mem_wr && mem_done) dev_mem[mem_addr[3:0]] <= mem_wdata;
   end

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle_ctl();
      addr_ld = 0; rd_go = 0; wr_go = 0; wait_done = 0;
      dreg_ld_int = 0; dreg_drv_int = 0; dreg_ld_ext = 0; dreg_drv_ext = 0;
   endtask

   task automatic next_step();
      @(negedge clk); #1;
   endtask

   // wait while stall is high; returns number of stalled cycles
   task automatic wait_stall(output int waited, input bit watch_dreg);
      waited = 0;
      #1;
      while (stall) begin
         if (watch_dreg) chk(ibus_out == exp_dreg, "R7 reg before done", ibus_out, exp_dreg);
         waited++;
         @(negedge clk); #2;
      end
      @(posedge clk);
   endtask

   // mode 0 plain, 1 disturb with addr/rd/wr pulses, 2 inside load on capture
   task automatic do_read(input int a, input int mode);
      int w;
      logic [DW-1:0] junk;
      junk = $urandom;
      next_step(); idle_ctl();
      ibus_in = DW'(a); addr_ld = 1; rd_go = 1;
      next_step(); idle_ctl();
      chk(mem_addr == DW'(a), "R2 address load", mem_addr, DW'(a));
      chk(mem_rd && !mem_wr, "R3 read request raised", {31'd0, mem_rd}, 1);
      dreg_ld_ext = 1; wait_done = 1;
      if (mode == 1) begin
         ibus_in = junk; addr_ld = 1; rd_go = 1; wr_go = 1; dreg_drv_int = 1;
      end else if (mode == 2) begin
         ibus_in = junk; dreg_ld_int = 1;
      end
      wait_stall(w, mode == 1);
      chk(w == last_lat, "R6 stall length", w, last_lat);
      next_step(); idle_ctl();
      dreg_drv_int = 1;
      #1;
      exp_dreg = exp_mem[a];
      chk(!mem_rd, "R3 read released", {31'd0, mem_rd}, 0);
      chk(ibus_out == exp_mem[a] && ibus_out_en,
          (mode == 2) ? "R11 capture beats inside load" : "R7 read data", ibus_out, exp_mem[a]);
      if (mode == 1) begin
         chk(mem_addr == DW'(a), "R2 address held while pending", mem_addr, DW'(a));
         chk(!mem_wr, "R5 requests ignored while pending", {31'd0, mem_wr}, 0);
      end
   endtask

   task automatic do_write(input int a, input logic [DW-1:0] d, input bit disturb);
      int w;
      next_step(); idle_ctl();
      ibus_in = DW'(a); addr_ld = 1;
      next_step(); idle_ctl();
      ibus_in = d; dreg_ld_int = 1; wr_go = 1;
      next_step(); idle_ctl();
      chk(mem_wr && !mem_rd, "R4 write request raised", {31'd0, mem_wr}, 1);
      dreg_drv_ext = 1; wait_done = 1;
      if (disturb) begin
         ibus_in = ~d; dreg_ld_int = 1;
      end
      #1;
      chk(mem_wdata == d && mem_wdata_en, "R10 write data driven", mem_wdata, d);
      wait_stall(w, 0);
      chk(w == last_lat, "R6 stall length on write", w, last_lat);
      exp_mem[a] = d;
      exp_dreg = d;
      next_step(); idle_ctl();
      #1;
      chk(!mem_wr, "R4 write released", {31'd0, mem_wr}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < NA; i++) begin
         dev_mem[i] = init_word(i);
         exp_mem[i] = init_word(i);
      end
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk(!mem_rd && !mem_wr && !stall && !ibus_out_en && !mem_wdata_en,
          "R1 reset controls", {27'd0, mem_rd, mem_wr, stall, ibus_out_en, mem_wdata_en}, 0);
      chk(mem_addr == 0, "R1 reset address", mem_addr, 0);
      @(negedge clk); rst_n = 1;

      // R6 wait with nothing outstanding
      next_step(); wait_done = 1; #1;
      chk(!stall, "R6 no stall when idle", {31'd0, stall}, 0);
      idle_ctl();

      // R9 idle internal drive is zero; R1 data register zero
      dreg_drv_int = 1; #1;
      chk(ibus_out == 0, "R1 reset data register", ibus_out, 0);
      idle_ctl();

      // directed corner cases
      force_lat = 0; do_read(3, 0);
      force_lat = 3; do_read(4, 1);
      force_lat = 0; do_read(6, 2);
      force_lat = 4; do_read(9, 2);
      force_lat = 3; do_write(7, 32'hCAFE_0007, 1);
      force_lat = 0; do_read(7, 0);
      force_lat = 0; do_write(2, 32'h1234_5678, 0);
      next_step(); idle_ctl(); #1;
      chk(ibus_out == 0 && !ibus_out_en, "R9 idle inside drive zero", ibus_out, 0);
      chk(mem_wdata == 0 && !mem_wdata_en, "R10 idle memory drive zero", mem_wdata, 0);

      // R5 both requests at idle
      force_lat = 2;
      next_step(); idle_ctl(); ibus_in = 32'd5; addr_ld = 1;
      next_step(); idle_ctl(); rd_go = 1; wr_go = 1;
      next_step(); idle_ctl(); #1;
      chk(mem_rd && !mem_wr, "R5 read wins over write", {30'd0, mem_rd, mem_wr}, 2);
      begin
         int w;
         dreg_ld_ext = 1; wait_done = 1;
         wait_stall(w, 0);
         next_step(); idle_ctl(); dreg_drv_int = 1; #1;
         chk(ibus_out == exp_mem[5] && !mem_wr, "R5 read result", ibus_out, exp_mem[5]);
      end

      // random traffic
      force_lat = -1;
      for (int n = 0; n < 80; n++) begin
         int a;
         a = int'($urandom % NA);
         if ($urandom % 2) do_write(a, $urandom, 0);
         else              do_read(a, 0);
      end
      for (int a = 0; a < NA; a++) do_read(a, 0);

      next_step(); idle_ctl();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule